// File: doc/BRIEF.md
# Rotate-and-Mask Integer Execution Unit

This unit executes one 32-bit integer instruction: the low word of a source register is rotated left by an immediate amount, then ANDed with a contiguous or wrap-around mask. The mask is given by a begin position and an end position. The unit decodes the instruction word itself and produces the 64-bit destination value and the destination register index. When the record flag is set, it also produces a 4-bit condition-field update. Logical left and right shifts, clearing of high or low bits, and bit-field extraction all map onto this single operation by choosing the rotate amount, the begin position and the end position.

The register file sits outside the unit, and so do fetch, the program counter and the sibling rotate variants. The surrounding pipeline presents an instruction word, the source operand and the current summary-overflow bit, all qualified by `valid_i`. One clock later the unit returns registered outputs qualified by `valid_o`. An instruction word whose primary opcode does not match is flagged as illegal and causes no write.

Top module: `rlm_exec_unit`

## Requirements
- R1: Instruction fields are numbered MSB-first. Vector bits [31:26] hold the primary opcode, [20:16] the destination index, [15:11] the rotate amount, [10:6] the mask begin, [5:1] the mask end and [0] the record flag. The word is legal only when the opcode equals 21, as in word 0x54000000.
- R2: A legal word sets `gpr_we_o`. An illegal word sets `illegal_o` and clears `gpr_we_o` and `cr_we_o`, and it drives `result_o` and `cr_o` to zero.
- R3: Only `src_i[31:0]` is used. It is rotated left by the 5-bit amount, 0 to 31.
- R4: When begin ≤ end, the mask has ones at MSB-first positions begin through end inclusive. Position p is vector bit 31−p.
- R5: When begin > end, the mask has ones everywhere except positions end+1 through begin−1.
- R6: `result_o[63:32]` is always zero, and `result_o[31:0]` equals the rotated word ANDed with the mask.
- R7: With the record flag set on a legal word, `cr_we_o` is 1 and `cr_o` = {LT, GT, EQ, SO}. LT, GT and EQ come from a signed compare of `result_o[31:0]` with zero. SO is a copy of `so_i`.
- R8: With the record flag clear, `cr_we_o` is 0 and `cr_o` is 0.
- R9: Outputs are registered. `valid_o` equals `valid_i` of the previous cycle, and the data outputs reflect the inputs sampled on that edge.
- R10: An asynchronous active-low reset clears `valid_o`, `gpr_we_o`, `cr_we_o`, `illegal_o` and `cr_o`.
- R11: Amount 0 with begin n and end 31 clears the top n bits. Amount n with begin 0 and end 31−n shifts left logically by n. Amount 32−n with begin n and end 31 shifts right logically by n.
- R12: `dst_idx_o` carries the destination field of the accepted word.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction and operand valid |
| instr_i | input | 32 | Instruction word |
| src_i | input | 64 | Source register value |
| so_i | input | 1 | Current summary-overflow bit |
| valid_o | output | 1 | Result valid, one cycle after `valid_i` |
| result_o | output | 64 | Zero-extended masked rotate result |
| dst_idx_o | output | 5 | Destination register index |
| gpr_we_o | output | 1 | Destination register write enable |
| cr_we_o | output | 1 | Condition field 0 write enable |
| cr_o | output | 4 | Condition field value {LT, GT, EQ, SO} |
| illegal_o | output | 1 | Primary opcode not recognised |

## Verification
The assertions check several properties on every cycle. The valid pipeline timing and the captured destination index always hold. The upper word of the result is always zero. Illegal words never raise a write enable. A clear record flag never writes the condition field. When the condition field is written, exactly one of LT, GT and EQ is set, and it agrees with the sign and zero state of the result.

Only the bench's scenarios can show that the rotate amount and the mask are correct. Its reference model covers both ordered and wrap-around masks, and the shift and clear equivalences are tested at their boundary amounts.

// File: rtl/rlm_pkg.sv
package rlm_pkg;
  localparam int unsigned XLEN     = 64;
  localparam int unsigned WLEN     = 32;
  localparam int unsigned IDXW     = 5;
  localparam int unsigned SHW      = $clog2(WLEN);
  localparam int unsigned OPCW     = 6;
  localparam int unsigned CRW      = 4;
  localparam logic [OPCW-1:0] OPC_RLM = 6'd21;

  typedef struct packed {
    logic            legal;
    logic [IDXW-1:0] dst;
    logic [SHW-1:0]  amt;
    logic [SHW-1:0]  mbeg;
    logic [SHW-1:0]  mend;
    logic            rec;
  } dec_t;
endpackage

// File: rtl/rlm_decode.sv
module rlm_decode
  import rlm_pkg::*;
(
  input  logic [WLEN-1:0] instr_i,
  output dec_t            dec_o
);
  logic unused_src_field;
  assign unused_src_field = ^instr_i[25:21];

  always_comb begin
    dec_o.legal = (instr_i[31:26] == OPC_RLM);
    dec_o.dst   = instr_i[20:16];
    dec_o.amt   = instr_i[15:11];
    dec_o.mbeg  = instr_i[10:6];
    dec_o.mend  = instr_i[5:1];
    dec_o.rec   = instr_i[0];
  end
endmodule

// File: rtl/rlm_rotate.sv
module rlm_rotate #(
  parameter int unsigned W   = 32,
  parameter int unsigned AMW = $clog2(W)
) (
  input  logic [W-1:0]   data_i,
  input  logic [AMW-1:0] amt_i,
  output logic [W-1:0]   data_o
);
  logic [AMW:0][W-1:0] stage;
  assign stage[0] = data_i;

  for (genvar s = 0; s < AMW; s++) begin : g_stage
    localparam int unsigned K = 1 << s;
    logic [W-1:0] rot;
    assign rot = {stage[s][W-1-K:0], stage[s][W-1:W-K]};
    assign stage[s+1] = amt_i[s] ? rot : stage[s];
  end

  assign data_o = stage[AMW];
endmodule

// File: rtl/rlm_mask.sv
module rlm_mask #(
  parameter int unsigned W   = 32,
  parameter int unsigned PW  = $clog2(W)
) (
  input  logic [PW-1:0] beg_i,
  input  logic [PW-1:0] end_i,
  output logic [W-1:0]  mask_o
);
  logic wrap;
  assign wrap = beg_i > end_i;

  // position p (MSB-first) maps to vector bit W-1-p
  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [PW-1:0] POS = PW'(W - 1 - i);
    logic ge_beg, le_end;
    assign ge_beg    = POS >= beg_i;
    assign le_end    = POS <= end_i;
    assign mask_o[i] = wrap ? (ge_beg | le_end) : (ge_beg & le_end);
  end
endmodule

// File: rtl/rlm_cond.sv
module rlm_cond #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] res_i,
  input  logic         so_i,
  output logic [3:0]   cr_o
);
  logic is_zero, is_neg;
  assign is_zero = (res_i == '0);
  assign is_neg  = res_i[W-1];
  assign cr_o    = {is_neg, !is_neg && !is_zero, is_zero, so_i};
endmodule

// File: rtl/rlm_exec_unit.sv
module rlm_exec_unit
  import rlm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [WLEN-1:0]  instr_i,
  input  logic [XLEN-1:0]  src_i,
  input  logic             so_i,
  output logic             valid_o,
  output logic [XLEN-1:0]  result_o,
  output logic [IDXW-1:0]  dst_idx_o,
  output logic             gpr_we_o,
  output logic             cr_we_o,
  output logic [CRW-1:0]   cr_o,
  output logic             illegal_o
);
  dec_t            dec;
  logic [WLEN-1:0] rot_w, mask_w, res_w;
  logic [CRW-1:0]  cr_w;
  logic            unused_src_hi;

  assign unused_src_hi = ^src_i[XLEN-1:WLEN];

  rlm_decode u_dec (.instr_i(instr_i), .dec_o(dec));

  rlm_rotate #(.W(WLEN)) u_rot (
    .data_i(src_i[WLEN-1:0]), .amt_i(dec.amt), .data_o(rot_w)
  );

  rlm_mask #(.W(WLEN)) u_mask (
    .beg_i(dec.mbeg), .end_i(dec.mend), .mask_o(mask_w)
  );

  assign res_w = dec.legal ? (rot_w & mask_w) : '0;

  rlm_cond #(.W(WLEN)) u_cond (.res_i(res_w), .so_i(so_i), .cr_o(cr_w));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      dst_idx_o <= '0;
      gpr_we_o  <= 1'b0;
      cr_we_o   <= 1'b0;
      cr_o      <= '0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= {{(XLEN-WLEN){1'b0}}, res_w};
        dst_idx_o <= dec.dst;
        gpr_we_o  <= dec.legal;
        cr_we_o   <= dec.legal & dec.rec;
        cr_o      <= (dec.legal & dec.rec) ? cr_w : '0;
        illegal_o <= !dec.legal;
      end
    end
  end
endmodule

// File: rtl/rlm_exec_unit_chk.sv
module rlm_exec_unit_chk
  import rlm_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [WLEN-1:0]  instr_i,
  input logic             valid_o,
  input logic [XLEN-1:0]  result_o,
  input logic [IDXW-1:0]  dst_idx_o,
  input logic             gpr_we_o,
  input logic             cr_we_o,
  input logic [CRW-1:0]   cr_o,
  input logic             illegal_o
);
  p_valid_follow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_dst_capture_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> dst_idx_o == $past(instr_i[20:16]));
  p_upper_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> result_o[XLEN-1:WLEN] == '0);
  p_illegal_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && illegal_o) |-> (!gpr_we_o && !cr_we_o && result_o == '0));
  p_legal_flag_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (illegal_o == ($past(instr_i[31:26]) != 6'd21)));
  p_no_record_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !instr_i[0]) |=> (!cr_we_o && cr_o == '0));
  p_cr_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cr_we_o) |-> $countones(cr_o[3:1]) == 1);
  p_cr_sign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cr_we_o) |->
      (cr_o[3] == result_o[WLEN-1] && cr_o[1] == (result_o[WLEN-1:0] == '0)));
endmodule

bind rlm_exec_unit rlm_exec_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
  .valid_o(valid_o), .result_o(result_o), .dst_idx_o(dst_idx_o),
  .gpr_we_o(gpr_we_o), .cr_we_o(cr_we_o), .cr_o(cr_o), .illegal_o(illegal_o)
);

// File: tb/rlm_exec_unit_tb.sv
module rlm_exec_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [63:0] src_i = '0;
  logic        so_i = 1'b0;
  logic        valid_o;
  logic [63:0] result_o;
  logic [4:0]  dst_idx_o;
  logic        gpr_we_o, cr_we_o, illegal_o;
  logic [3:0]  cr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rlm_exec_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .src_i(src_i), .so_i(so_i), .valid_o(valid_o), .result_o(result_o),
    .dst_idx_o(dst_idx_o), .gpr_we_o(gpr_we_o), .cr_we_o(cr_we_o),
    .cr_o(cr_o), .illegal_o(illegal_o)
  );

  function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] ra,
                                     logic [4:0] sh, logic [4:0] mb,
                                     logic [4:0] me, logic rc);
    return {op, 5'd3, ra, sh, mb, me, rc};
  endfunction

  function automatic logic [31:0] ref_mask(int b, int e);
    logic [31:0] m = '0;
    for (int p = 0; p < 32; p++) begin
      bit on = (b <= e) ? (p >= b && p <= e) : !(p > e && p < b);
      m[31-p] = on;
    end
    return m;
  endfunction

  function automatic logic [31:0] ref_res(logic [31:0] ins, logic [63:0] s);
    logic [31:0] w = s[31:0];
    int sh = int'(ins[15:11]);
    logic [31:0] r = (sh == 0) ? w : ((w << sh) | (w >> (32 - sh)));
    if (ins[31:26] != 6'd21) return '0;
    return r & ref_mask(int'(ins[10:6]), int'(ins[5:1]));
  endfunction

  task automatic check(string tag, bit ok, string what, logic [63:0] act,
                       logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive one vector, sample one cycle later on the falling edge
  task automatic run(string tag, logic [31:0] ins, logic [63:0] s, logic so);
    logic        legal = (ins[31:26] == 6'd21);
    logic [31:0] r = ref_res(ins, s);
    logic        rec = legal & ins[0];
    logic [3:0]  cr = rec ? {r[31], !r[31] && r != 0, r == 0, so} : 4'h0;
    @(negedge clk_i);
    valid_i = 1'b1; instr_i = ins; src_i = s; so_i = so;
    @(negedge clk_i);
    valid_i = 1'b0;
    check(tag, valid_o && result_o == {32'h0, r} && dst_idx_o == ins[20:16] &&
          gpr_we_o == legal && illegal_o == !legal && cr_we_o == rec &&
          cr_o == cr,
          "vec", {valid_o, cr_we_o, cr_o, result_o[31:0]},
          {1'b1, rec, cr, r});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h5eed_1234;
    void'($urandom(seed));
    #(CLK_PERIOD * 2 + 1);
    // R10: reset state
    check("R10", !valid_o && !gpr_we_o && !cr_we_o && !illegal_o && cr_o == 0,
          "reset", {valid_o, gpr_we_o, cr_we_o, illegal_o, cr_o}, 64'h0);
    rst_ni = 1'b1;

    // R3/R4: plain rotate, full mask
    run("R3", mk(6'd21, 5'd7, 5'd8, 5'd0, 5'd31, 1'b0), 64'hffff_0000_1234_5678, 1'b0);
    run("R4", mk(6'd21, 5'd1, 5'd0, 5'd8, 5'd15, 1'b0), 64'h0000_0000_dead_beef, 1'b0);
    run("R4", mk(6'd21, 5'd2, 5'd0, 5'd31, 5'd31, 1'b0), 64'h0000_0000_0000_0001, 1'b0);
    // R5: wrap-around masks
    run("R5", mk(6'd21, 5'd4, 5'd0, 5'd24, 5'd7, 1'b0), 64'h0000_0000_ffff_ffff, 1'b0);
    run("R5", mk(6'd21, 5'd4, 5'd5, 5'd31, 5'd0, 1'b0), 64'h0000_0000_a5a5_5a5a, 1'b0);
    // R11: shift/clear equivalences at boundaries
    run("R11", mk(6'd21, 5'd9, 5'd0, 5'd12, 5'd31, 1'b0), 64'h0000_0000_ffff_ffff, 1'b0);
    run("R11", mk(6'd21, 5'd9, 5'd4, 5'd0, 5'd27, 1'b0), 64'h0000_0000_8765_4321, 1'b0);
    run("R11", mk(6'd21, 5'd9, 5'd28, 5'd4, 5'd31, 1'b0), 64'h0000_0000_8765_4321, 1'b0);
    run("R11", mk(6'd21, 5'd9, 5'd1, 5'd31, 5'd31, 1'b0), 64'h0000_0000_8000_0000, 1'b0);
    // R7: record forms: negative, positive, zero, SO copy
    run("R7", mk(6'd21, 5'd5, 5'd0, 5'd0, 5'd31, 1'b1), 64'h0000_0000_8000_0000, 1'b1);
    run("R7", mk(6'd21, 5'd5, 5'd0, 5'd1, 5'd31, 1'b1), 64'h0000_0000_7fff_ffff, 1'b0);
    run("R7", mk(6'd21, 5'd5, 5'd3, 5'd16, 5'd31, 1'b1), 64'hffff_ffff_0000_0000, 1'b1);
    // R8: record flag clear with so set
    run("R8", mk(6'd21, 5'd6, 5'd0, 5'd0, 5'd31, 1'b0), 64'h0, 1'b1);
    // R2/R1: illegal opcodes
    run("R2", mk(6'd20, 5'd6, 5'd3, 5'd0, 5'd31, 1'b1), 64'h1234, 1'b1);
    run("R1", mk(6'd23, 5'd6, 5'd3, 5'd0, 5'd31, 1'b0), 64'h1234, 1'b0);
    // R6/R12: dirty upper source word and index
    run("R6", mk(6'd21, 5'd31, 5'd16, 5'd0, 5'd31, 1'b0), 64'hffff_ffff_0000_ffff, 1'b0);
    run("R12", mk(6'd21, 5'd0, 5'd2, 5'd2, 5'd29, 1'b1), 64'h0000_0000_0f0f_0f0f, 1'b0);

    // R9: idle cycle drops valid_o
    @(negedge clk_i);
    check("R9", !valid_o, "idle valid", {63'h0, valid_o}, 64'h0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [5:0]  op = ($urandom % 10 == 0) ? 6'($urandom) : 6'd21;
      logic [31:0] ins = {op, 26'($urandom)};
      run("R3", ins, {32'($urandom), 32'($urandom)}, 1'($urandom));
    end

    // R10: asynchronous reset mid-stream
    @(negedge clk_i);
    valid_i = 1'b1; instr_i = mk(6'd21, 5'd1, 5'd0, 5'd0, 5'd31, 1'b1); src_i = 64'h5;
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    check("R10", !valid_o && !cr_we_o && cr_o == 0 && !gpr_we_o, "async reset",
          {valid_o, cr_we_o, gpr_we_o, cr_o}, 64'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule